// File: doc/BRIEF.md
# Bus Test Access Controller

This block lets an external tester take over an on-chip system bus through a narrow test port. The tester drives two request lines, `req_a` and `req_b`. The block answers on `tst_ack` and moves through four phases: NORMAL, LOAD, READ and TURN. All state changes happen on the falling edge of `tclk`. The requests are sampled only on a falling edge where `tst_ack` is high. The one exception is NORMAL: there `req_a` is treated as asynchronous and passes through a two-stage synchroniser before it can move the machine into LOAD.

In LOAD the tester writes either the bus address or an 8-bit control vector from `tdin`. The control vector sets the transfer size, protection and lock driven onto the bus. It also decides whether the address steps forward after each completed transfer. In READ the block requests bus transfers and captures the returned data. Leaving READ always passes through a single TURN phase before the tester may drive again.

The phase encoding on `phase` is NORMAL=0, LOAD=1, READ=2, TURN=3. The transitions are:
- NORMAL→LOAD when the synchronised `req_a` is high.
- LOAD→NORMAL when both requests are low.
- LOAD→READ when `req_a` is low and `req_b` is high.
- READ→TURN when the request pair is anything other than `req_a` low with `req_b` high.
- TURN→LOAD when `req_a` is high.
- TURN→READ when `req_a` is low and `req_b` is high.
- TURN→NORMAL when both requests are low.

Top module: `test_bus_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`) forces the following: `phase`=0 (NORMAL), `bus_req`=0, `tst_ack`=1, `bus_addr`=0, and an invalid control vector, which gives the default bus attributes.
- R2: In NORMAL, `req_b` has no effect. If `req_a` is high before falling edge k and held there, `phase` still reads 0 after edges k and k+1 and reads 1 (LOAD) after edge k+2. The synchroniser is cleared whenever the phase is not NORMAL.
- R3: The requests are acted on only at falling edges where `tst_ack` is high. In READ, `tst_ack` follows `bus_rdy`. While `bus_rdy` is low, the phase, `bus_addr` and `rd_data` hold. In every other phase, `tst_ack` is 1.
- R4: In LOAD, the pair `req_a`=1 with `req_b`=0 loads data at the edge. With `load_ctl`=0 it loads `tdin` into the address. With `load_ctl`=1 it loads `tdin[7:0]` into the control vector, and `tdin[15:8]` and above are ignored. Both requests high keeps LOAD and loads nothing. Both low goes to NORMAL. `req_a`=0 with `req_b`=1 goes to READ. The address never changes in NORMAL or TURN.
- R5: In READ, `bus_req` is 1. At each edge where `bus_rdy` is high, `rd_data` captures `bus_rdata`. The machine stays in READ when `req_a`=0 and `req_b`=1, and goes to TURN otherwise.
- R6: TURN lasts exactly one sampled edge. It then goes to LOAD if `req_a`=1, to READ if `req_a`=0 and `req_b`=1, and to NORMAL if both are low.
- R7: When control bit 0 (valid) is set, the bus attributes follow the control vector: `bus_size`=ctl[3:2], `bus_lock`=ctl[4], `bus_prot`=ctl[6:5]. Bit 1 has no effect.
- R8: When control bit 0 is clear, the defaults apply: `bus_size`=2'b10 (word), `bus_lock`=0, `bus_prot`=2'b11 (privileged data).
- R9: After each completed READ transfer, the address steps by 1, 2 or 4 bytes for `bus_size` 00, 01 or 10, and by 4 for 11. It steps only when control bits 7 and 0 are both set; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Tester request A (asynchronous in NORMAL) |
| req_b | input | 1 | Tester request B |
| load_ctl | input | 1 | In LOAD: 1 writes the control vector, 0 writes the address |
| tdin | input | ADDR_W | Tester write data |
| bus_rdy | input | 1 | Bus transfer complete |
| bus_rdata | input | DATA_W | Bus read data |
| tst_ack | output | 1 | Acknowledge to the tester |
| phase | output | 2 | Current phase (0 NORMAL, 1 LOAD, 2 READ, 3 TURN) |
| bus_req | output | 1 | Bus transfer request (READ phase) |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_prot | output | 2 | Protection code |
| bus_lock | output | 1 | Locked transfer |
| rd_data | output | DATA_W | Last data captured from the bus |

## Verification
The assertions assume that `req_a`, `req_b`, `bus_rdy` and `bus_rdata` are stable around each falling edge of `tclk`. Outside NORMAL, the request pair is assumed to be meaningful only when `tst_ack` is high. The stimulus changes every input just after the rising edge, half a period away from the edge where the block samples. After leaving LOAD or TURN for NORMAL, the stimulus holds `req_a` low or raises it on purpose, so that re-entry latency is measured from a cleared synchroniser.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        PH_NORMAL = 2'd0,
        PH_LOAD   = 2'd1,
        PH_READ   = 2'd2,
        PH_TURN   = 2'd3
    } phase_e;

    // byte count for a size code; the reserved code steps like a word
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tbc_sync.sv
module tbc_sync #(
    parameter int STAGES = 2
) (
    input  logic tclk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(negedge tclk or negedge rst_n) begin
                if (!rst_n)   chain <= '0;
                else if (clr) chain <= '0;
                else          chain <= d;
            end
        end else begin : g_many
            always_ff @(negedge tclk or negedge rst_n) begin
                if (!rst_n)   chain <= '0;
                else if (clr) chain <= '0;
                else          chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tbc_fsm.sv
module tbc_fsm
    import tbc_pkg::*;
(
    input  logic   tclk,
    input  logic   rst_n,
    input  logic   a_sync,
    input  logic   req_a,
    input  logic   req_b,
    input  logic   smp,
    output phase_e st
);
    phase_e nxt;

    always_ff @(negedge tclk or negedge rst_n) begin
        if (!rst_n) st <= PH_NORMAL;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            PH_NORMAL: if (a_sync) nxt = PH_LOAD;
            PH_LOAD: begin
                if (smp) begin
                    if (!req_a && !req_b)     nxt = PH_NORMAL;
                    else if (!req_a && req_b) nxt = PH_READ;
                end
            end
            PH_READ: begin
                if (smp && !(!req_a && req_b)) nxt = PH_TURN;
            end
            PH_TURN: begin
                if (smp) begin
                    if (req_a)      nxt = PH_LOAD;
                    else if (req_b) nxt = PH_READ;
                    else            nxt = PH_NORMAL;
                end
            end
        endcase
    end
endmodule

// File: rtl/tbc_ctlreg.sv
module tbc_ctlreg
    import tbc_pkg::*;
(
    input  logic             tclk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CTL_W-1:0] din,
    output logic [1:0]       size,
    output logic [1:0]       prot,
    output logic             lock,
    output logic             inc_en
);
    logic [CTL_W-1:0] ctl_q;

    always_ff @(negedge tclk or negedge rst_n) begin
        if (!rst_n)  ctl_q <= '0;
        else if (ld) ctl_q <= din;
    end

    always_comb begin
        if (ctl_q[0]) begin
            size = ctl_q[3:2];
            lock = ctl_q[4];
            prot = ctl_q[6:5];
        end else begin
            size = 2'b10;
            lock = 1'b0;
            prot = 2'b11;
        end
        inc_en = ctl_q[0] & ctl_q[7];
    end
endmodule

// File: rtl/tbc_addr.sv
module tbc_addr
    import tbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              tclk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] din,
    input  logic              step,
    input  logic              inc_en,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] delta;

    assign delta = {{(ADDR_W-3){1'b0}}, size_bytes(size)};

    always_ff @(negedge tclk or negedge rst_n) begin
        if (!rst_n)                addr <= '0;
        else if (ld)               addr <= din;
        else if (step && inc_en)   addr <= addr + delta;
    end
endmodule

// File: rtl/test_bus_ctrl.sv
module test_bus_ctrl
    import tbc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tclk,
    input  logic              rst_n,
    input  logic              req_a,
    input  logic              req_b,
    input  logic              load_ctl,
    input  logic [ADDR_W-1:0] tdin,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              tst_ack,
    output logic [1:0]        phase,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [1:0]        bus_prot,
    output logic              bus_lock,
    output logic [DATA_W-1:0] rd_data
);
    phase_e st;
    logic   a_sync;
    logic   load_stb;
    logic   xfer_done;
    logic   inc_en;

    tbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .tclk(tclk), .rst_n(rst_n), .clr(st != PH_NORMAL),
        .d(req_a), .q(a_sync)
    );

    tbc_fsm u_fsm (
        .tclk(tclk), .rst_n(rst_n), .a_sync(a_sync),
        .req_a(req_a), .req_b(req_b), .smp(tst_ack), .st(st)
    );

    always_comb begin
        tst_ack   = (st == PH_READ) ? bus_rdy : 1'b1;
        bus_req   = (st == PH_READ);
        load_stb  = (st == PH_LOAD) && req_a && !req_b;
        xfer_done = (st == PH_READ) && bus_rdy;
        phase     = st;
    end

    tbc_ctlreg u_ctl (
        .tclk(tclk), .rst_n(rst_n), .ld(load_stb && load_ctl),
        .din(tdin[CTL_W-1:0]), .size(bus_size), .prot(bus_prot),
        .lock(bus_lock), .inc_en(inc_en)
    );

    tbc_addr #(.ADDR_W(ADDR_W)) u_addr (
        .tclk(tclk), .rst_n(rst_n), .ld(load_stb && !load_ctl),
        .din(tdin), .step(xfer_done), .inc_en(inc_en),
        .size(bus_size), .addr(bus_addr)
    );

    always_ff @(negedge tclk or negedge rst_n) begin
        if (!rst_n)         rd_data <= '0;
        else if (xfer_done) rd_data <= bus_rdata;
    end
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              tclk,
    input logic              rst_n,
    input logic              req_a,
    input logic              req_b,
    input logic              tst_ack,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              inc_en
);
    AST_NORMAL_EXIT: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase == 2'd0 || phase == 2'd1)); // R2

    AST_HOLD_NO_ACK: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd2 && !tst_ack) |=> (phase == 2'd2 && $stable(bus_addr) && $stable(rd_data))); // R3

    AST_ADDR_QUIET: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd0 || phase == 2'd3) |=> $stable(bus_addr)); // R4

    AST_READ_LEAVE: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd2 && tst_ack && !(!req_a && req_b)) |=> (phase == 2'd3)); // R5

    AST_TURN_ONCE: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd3) |=> (phase != 2'd3)); // R6

    AST_NO_STEP: assert property (@(negedge tclk) disable iff (!rst_n)
        (phase == 2'd2 && !inc_en) |=> $stable(bus_addr)); // R9
endmodule

bind test_bus_ctrl tbc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .tclk(tclk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .tst_ack(tst_ack), .phase(phase), .bus_addr(bus_addr),
    .rd_data(rd_data), .inc_en(inc_en)
);

// File: tb/sim_test_bus_ctrl.sv
`timescale 1ns/100ps
module sim_test_bus_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          tclk = 1'b0;
    logic          rst_n, req_a, req_b, load_ctl, bus_rdy;
    logic [AW-1:0] tdin;
    logic [DW-1:0] bus_rdata;
    logic          tst_ack, bus_req, bus_lock;
    logic [1:0]    phase, bus_size, bus_prot;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]    cur_ctl;
    logic [AW-1:0] exp_addr;

    always #2 tclk = ~tclk;

    test_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .tclk(tclk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
        .load_ctl(load_ctl), .tdin(tdin), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata), .tst_ack(tst_ack), .phase(phase),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_prot(bus_prot), .bus_lock(bus_lock), .rd_data(rd_data)
    );

    task automatic step();
        @(posedge tclk);
        #0.5;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] e_size(input logic [7:0] c);
        return c[0] ? c[3:2] : 2'b10;
    endfunction
    function automatic logic [1:0] e_prot(input logic [7:0] c);
        return c[0] ? c[6:5] : 2'b11;
    endfunction
    function automatic logic e_lock(input logic [7:0] c);
        return c[0] ? c[4] : 1'b0;
    endfunction
    function automatic logic [AW-1:0] e_step(input logic [7:0] c);
        if (!(c[0] && c[7])) return '0;
        case (c[3:2])
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; req_a = 0; req_b = 0; load_ctl = 0; bus_rdy = 0;
        tdin = '0; bus_rdata = '0;
        step(); step(); step();
        check("R1 phase", phase, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 ack", tst_ack, 1);
        check("R1 addr", bus_addr, 0);
        check("R8 size", bus_size, 2'b10);
        check("R8 prot", bus_prot, 2'b11);
        check("R8 lock", bus_lock, 0);
        cur_ctl = 8'h00; exp_addr = '0;
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_enter();
        req_b = 1;
        step(); step(); step();
        check("R2 req_b ignored", phase, 0);
        req_b = 0; req_a = 1;
        step(); check("R2 edge k", phase, 0);
        step(); check("R2 edge k+1", phase, 0);
        step(); check("R2 edge k+2", phase, 1);
    endtask

    task automatic t_load(input logic [7:0] c, input logic [AW-1:0] a);
        req_a = 1; req_b = 0;
        load_ctl = 1; tdin = {24'hA5C3F0, c};
        step();
        cur_ctl = c;
        check("R7 size", bus_size, e_size(c));
        check("R7 prot", bus_prot, e_prot(c));
        check("R7 lock", bus_lock, e_lock(c));
        load_ctl = 0; tdin = a;
        step();
        exp_addr = a;
        check("R4 addr load", bus_addr, exp_addr);
        req_b = 1; tdin = ~a;
        step();
        check("R4 both high stays", phase, 1);
        check("R4 both high no load", bus_addr, exp_addr);
    endtask

    task automatic t_read(input int n, input logic [DW-1:0] base);
        req_a = 0; req_b = 1; bus_rdy = 0;
        step();
        check("R5 in read", phase, 2);
        check("R5 bus_req", bus_req, 1);
        check("R3 ack follows rdy", tst_ack, 0);
        step();
        check("R3 hold phase", phase, 2);
        check("R3 hold addr", bus_addr, exp_addr);
        for (int i = 0; i < n; i++) begin
            bus_rdy = 1; bus_rdata = base + i;
            req_b = (i < n - 1);
            step();
            exp_addr = exp_addr + e_step(cur_ctl);
            check("R5 rd_data", rd_data, base + i);
            check("R9 addr step", bus_addr, exp_addr);
        end
        check("R5 exit to turn", phase, 3);
        bus_rdy = 0;
    endtask

    task automatic t_turn(input logic a, input logic b, input logic [1:0] exp_ph);
        req_a = a; req_b = b;
        step();
        check("R6 turn exit", phase, exp_ph);
        check("R4 addr quiet", bus_addr, exp_addr);
    endtask

    initial begin
        #(4 * 20000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_enter();
        t_load(8'h85, 32'h0000_0100);   // size 01 inc
        t_read(3, 32'hD000_0000);
        t_turn(1, 0, 2'd1);
        t_load(8'h89, 32'h0000_0200);   // size 10 inc
        t_read(2, 32'hD100_0000);
        t_turn(0, 1, 2'd2);
        t_read(1, 32'hD200_0000);
        t_turn(1, 1, 2'd1);
        t_load(8'hD1, 32'h0000_0300);   // size 00, lock, prot 10
        t_read(2, 32'hD300_0000);
        t_turn(1, 0, 2'd1);
        t_load(8'h80, 32'h0000_0400);   // invalid: defaults, no step (R8, R9)
        check("R8 invalid size", bus_size, 2'b10);
        t_read(2, 32'hD400_0000);
        t_turn(1, 0, 2'd1);
        t_load(8'h8F, 32'h0000_0500);   // reserved bit set, size 11 steps 4 (R7, R9)
        t_read(1, 32'hD500_0000);
        t_turn(0, 0, 2'd0);
        check("R3 ack in normal", tst_ack, 1);
        check("R1 bus_req idle", bus_req, 0);
        t_enter();                      // synchroniser cleared on re-entry (R2)
        req_a = 0; req_b = 0;
        step();
        check("R4 load to normal", phase, 0);
        step(); step();
        check("R2 stays normal", phase, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule